// File: doc/BRIEF.md
# Decimal Keypad Operand Entry Unit

This block sits between a bank of active-low push keys and the arithmetic of a small calculator. Ten digit keys and two operation keys (plus and minus) come in without synchronisation. The block turns each digit press into a value and builds a pending entry of one or two digits. It then hands that entry down a two-deep operand pipeline whenever an operation key is pressed. The pending entry drives a display, and the two latched operands feed the adder.

A first digit is taken as it is. A later digit turns the entry into a two-digit number by adding ten to the newest digit, with the result held at 15 at most. An operation key copies the entry into the first operand and pushes the old first operand into the second. The entry is not wiped at that moment. A countdown of `CLR_DLY` cycles runs first, and the entry is cleared when it ends. A control state machine has four states: `ST_EMPTY` (no digit yet), `ST_ONE` (one digit held), `ST_TWO` (two-digit value held) and `ST_WAIT` (clear countdown running). Its transitions are:
- first-digit: `ST_EMPTY` to `ST_ONE` on a digit press.
- next-digit: `ST_ONE` or `ST_TWO` to `ST_TWO` on a digit press.
- transfer: any state other than `ST_WAIT` to `ST_WAIT` on an operation press.
- restart: `ST_WAIT` to `ST_WAIT` on an operation press.
- expire: `ST_WAIT` to `ST_EMPTY` when the countdown reaches its end.

Top module: `keypad_entry`

## Requirements
- R1: After reset the entry value and both operands are zero.
- R2: Every key passes through a two-flop synchroniser. A digit press is the cycle in which the set of active digit keys goes from empty to non-empty. It takes effect at the third rising clock edge after the key input goes low. Holding keys down, or adding keys while others are held, gives no further press.
- R3: When several digit keys are active in the press cycle, the highest-numbered one is used. Bit i of `digit_key_n` is digit i.
- R4: A digit press in `ST_EMPTY` sets the entry to that digit.
- R5: A digit press in `ST_ONE` or `ST_TWO` sets the entry to ten plus that digit, held at 15 for digits 6 to 9.
- R6: A plus or minus press copies the entry into `operand_first` and the old `operand_first` into `operand_second`, on the same edge in which a digit press would take effect. Plus and minus together count as one press. A digit press in the same cycle is ignored.
- R7: The entry is cleared to zero exactly `CLR_DLY` cycles after the transfer edge. Digit presses during that wait are ignored.
- R8: An operation press during the wait transfers the still-held entry again and restarts the full `CLR_DLY` countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_key_n | input | NUM_DIGITS | Digit keys, active low, bit i is digit i |
| plus_key_n | input | 1 | Plus key, active low |
| minus_key_n | input | 1 | Minus key, active low |
| entry_value | output | ENTRY_W | Pending entry for display |
| operand_first | output | ENTRY_W | Most recently latched operand |
| operand_second | output | ENTRY_W | Operand latched before it |

## Verification
A key change driven between edges reaches `entry_value` and the operand outputs at the third rising edge: two edges go to the synchroniser and one to the edge flop and result registers. The entry clear lands `CLR_DLY` edges after that transfer edge. The bench keeps a history of the key vectors sampled at each edge and uses it to derive each press from the samples two and three edges back. It updates its behavioural model on that edge and compares all three outputs on the following falling edge. Directed checks are placed a known number of falling edges after each drive, so that they sit before or after the latency and the expiry edge, and never on them.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_ONE,
        ST_TWO,
        ST_WAIT
    } kp_state_e;

    localparam int KP_TEN = 10;

endpackage

// File: rtl/kp_sync_edge.sv
module kp_sync_edge #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_act,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= raw_act;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    // one extra flop keeps the previous synchronised level for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv <= '0;
        else        prv <= stg[STAGES-1];
    end

    assign lvl = stg[STAGES-1];

endmodule

// File: rtl/kp_prio_enc.sv
module kp_prio_enc #(
    parameter int NUM_DIGITS = 10,
    parameter int ENC_W      = 4
) (
    input  logic [NUM_DIGITS-1:0] lvl,
    output logic [ENC_W-1:0]      digit,
    output logic                  valid
);

    always_comb begin
        digit = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (lvl[i]) digit = ENC_W'(i);
        end
    end

    assign valid = |lvl;

endmodule

// File: rtl/kp_entry_fsm.sv
module kp_entry_fsm
    import kp_pkg::*;
#(
    parameter int ENC_W   = 4,
    parameter int ENTRY_W = 4,
    parameter int CLR_DLY = 2000,
    parameter int CNT_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               digit_press,
    input  logic               op_press,
    input  logic [ENC_W-1:0]   digit_val,
    output logic [ENTRY_W-1:0] entry_value,
    output kp_state_e          state_q,
    output logic [CNT_W-1:0]   clr_cnt
);

    localparam int MAXV = (1 << ENTRY_W) - 1;

    kp_state_e          state_d;
    logic               expire;
    logic [ENTRY_W:0]   sum_two;
    logic [ENTRY_W-1:0] val_two;
    logic [ENTRY_W-1:0] val_one;

    assign expire  = (state_q == ST_WAIT) && (clr_cnt == '0) && !op_press;
    assign sum_two = (ENTRY_W+1)'(KP_TEN) + (ENTRY_W+1)'(digit_val);
    assign val_two = (sum_two > (ENTRY_W+1)'(MAXV)) ? ENTRY_W'(MAXV) : sum_two[ENTRY_W-1:0];
    assign val_one = ENTRY_W'(digit_val);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op_press)         state_d = ST_WAIT;
                else if (digit_press) state_d = ST_ONE;
            end
            ST_ONE, ST_TWO: begin
                if (op_press)         state_d = ST_WAIT;
                else if (digit_press) state_d = ST_TWO;
            end
            ST_WAIT: begin
                if (expire)           state_d = ST_EMPTY;
            end
            default:                  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs: entry register and clear countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_value <= '0;
            clr_cnt     <= '0;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (op_press)         clr_cnt     <= CNT_W'(CLR_DLY - 1);
                    else if (digit_press) entry_value <= val_one;
                end
                ST_ONE, ST_TWO: begin
                    if (op_press)         clr_cnt     <= CNT_W'(CLR_DLY - 1);
                    else if (digit_press) entry_value <= val_two;
                end
                ST_WAIT: begin
                    if (op_press)         clr_cnt     <= CNT_W'(CLR_DLY - 1);
                    else if (expire)      entry_value <= '0;
                    else                  clr_cnt     <= clr_cnt - 1'b1;
                end
                default: begin
                    entry_value <= '0;
                    clr_cnt     <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/kp_operand_pipe.sv
module kp_operand_pipe #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [W-1:0]            din,
    output logic [DEPTH-1:0][W-1:0] dout
);

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_opnd
            if (k == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        dout[k] <= '0;
                    else if (shift_en) dout[k] <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        dout[k] <= '0;
                    else if (shift_en) dout[k] <= dout[k-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/keypad_entry.sv
module keypad_entry
    import kp_pkg::*;
#(
    parameter int NUM_DIGITS  = 10,
    parameter int ENTRY_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CLR_DLY     = 2000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_DIGITS-1:0] digit_key_n,
    input  logic                  plus_key_n,
    input  logic                  minus_key_n,
    output logic [ENTRY_W-1:0]    entry_value,
    output logic [ENTRY_W-1:0]    operand_first,
    output logic [ENTRY_W-1:0]    operand_second
);

    localparam int ENC_W  = $clog2(NUM_DIGITS);
    localparam int KEYS_W = NUM_DIGITS + 2;
    localparam int CNT_W  = $clog2(CLR_DLY + 1);
    localparam int OPND_N = 2;
    localparam int PLUS_B = NUM_DIGITS;
    localparam int MIN_B  = NUM_DIGITS + 1;

    logic [KEYS_W-1:0]              key_lvl;
    logic [KEYS_W-1:0]              key_prv;
    logic [NUM_DIGITS-1:0]          dig_lvl;
    logic                           digit_press;
    logic                           op_press;
    logic [ENC_W-1:0]               enc_digit;
    logic                           enc_valid;
    kp_state_e                      state_q;
    logic [CNT_W-1:0]               clr_cnt;
    logic [OPND_N-1:0][ENTRY_W-1:0] opnd;

    kp_sync_edge #(
        .W      (KEYS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_act (~{minus_key_n, plus_key_n, digit_key_n}),
        .lvl     (key_lvl),
        .prv     (key_prv)
    );

    assign dig_lvl     = key_lvl[NUM_DIGITS-1:0];
    assign digit_press = (|dig_lvl) && !(|key_prv[NUM_DIGITS-1:0]);
    assign op_press    = (key_lvl[PLUS_B] && !key_prv[PLUS_B]) ||
                         (key_lvl[MIN_B]  && !key_prv[MIN_B]);

    kp_prio_enc #(
        .NUM_DIGITS (NUM_DIGITS),
        .ENC_W      (ENC_W)
    ) u_enc (
        .lvl   (dig_lvl),
        .digit (enc_digit),
        .valid (enc_valid)
    );

    kp_entry_fsm #(
        .ENC_W   (ENC_W),
        .ENTRY_W (ENTRY_W),
        .CLR_DLY (CLR_DLY),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .digit_press (digit_press),
        .op_press    (op_press),
        .digit_val   (enc_digit),
        .entry_value (entry_value),
        .state_q     (state_q),
        .clr_cnt     (clr_cnt)
    );

    kp_operand_pipe #(
        .W     (ENTRY_W),
        .DEPTH (OPND_N)
    ) u_opnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (op_press),
        .din      (entry_value),
        .dout     (opnd)
    );

    assign operand_first  = opnd[0];
    assign operand_second = opnd[1];

endmodule

// File: rtl/keypad_entry_chk.sv
module keypad_entry_chk
    import kp_pkg::*;
#(
    parameter int NUM_DIGITS = 10,
    parameter int ENTRY_W    = 4,
    parameter int ENC_W      = 4,
    parameter int CLR_DLY    = 2000,
    parameter int CNT_W      = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_DIGITS-1:0] dig_lvl,
    input  logic                  digit_press,
    input  logic                  op_press,
    input  logic [ENC_W-1:0]      enc_digit,
    input  logic                  enc_valid,
    input  kp_state_e             state_q,
    input  logic [CNT_W-1:0]      clr_cnt,
    input  logic [ENTRY_W-1:0]    entry_value,
    input  logic [ENTRY_W-1:0]    operand_first,
    input  logic [ENTRY_W-1:0]    operand_second
);

    assert_entry_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_press && !(digit_press && state_q != ST_WAIT) &&
         !(state_q == ST_WAIT && clr_cnt == '0))
        |=> $stable(entry_value));

    assert_highest_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> ((dig_lvl >> enc_digit) == NUM_DIGITS'(1)));

    assert_first_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && digit_press && !op_press)
        |=> entry_value == ENTRY_W'($past(enc_digit)));

    assert_two_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWO) |-> (entry_value >= ENTRY_W'(KP_TEN)));

    assert_operand_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_press |=> (operand_first == $past(entry_value)) &&
                     (operand_second == $past(operand_first)));

    assert_operands_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_press |=> $stable(operand_first) && $stable(operand_second));

    assert_clear_on_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && clr_cnt == '0 && !op_press)
        |=> (entry_value == '0) && (state_q == ST_EMPTY));

    assert_restart_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_press |=> (state_q == ST_WAIT) && (clr_cnt == CNT_W'(CLR_DLY - 1)));

endmodule

bind keypad_entry keypad_entry_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .ENTRY_W    (ENTRY_W),
    .ENC_W      (ENC_W),
    .CLR_DLY    (CLR_DLY),
    .CNT_W      (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dig_lvl        (dig_lvl),
    .digit_press    (digit_press),
    .op_press       (op_press),
    .enc_digit      (enc_digit),
    .enc_valid      (enc_valid),
    .state_q        (state_q),
    .clr_cnt        (clr_cnt),
    .entry_value    (entry_value),
    .operand_first  (operand_first),
    .operand_second (operand_second)
);

// File: tb/keypad_entry_tb_top.sv
`timescale 1ns/1ps
module keypad_entry_tb_top;

    localparam int ND  = 10;
    localparam int EW  = 4;
    localparam int CLR = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] digit_n = '1;
    logic          plus_n = 1'b1;
    logic          minus_n = 1'b1;
    logic [EW-1:0] entry_value, operand_first, operand_second;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    keypad_entry #(
        .NUM_DIGITS (ND),
        .ENTRY_W    (EW),
        .CLR_DLY    (CLR)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .digit_key_n    (digit_n),
        .plus_key_n     (plus_n),
        .minus_key_n    (minus_n),
        .entry_value    (entry_value),
        .operand_first  (operand_first),
        .operand_second (operand_second)
    );

    // behavioural reference: sampled key history, active high {minus, plus, digits}
    logic [ND+1:0] h0, h1, h2;
    int m_state, m_entry, m_a, m_b, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            h0 = '0; h1 = '0; h2 = '0;
            m_state = 0; m_entry = 0; m_a = 0; m_b = 0; m_cnt = 0;
        end else begin
            bit dp, op;
            int dv;
            dp = (|h1[ND-1:0]) && !(|h2[ND-1:0]);
            op = (h1[ND] && !h2[ND]) || (h1[ND+1] && !h2[ND+1]);
            dv = 0;
            for (int i = 0; i < ND; i++) if (h1[i]) dv = i;
            if (op) begin
                m_b = m_a; m_a = m_entry; m_state = 3; m_cnt = CLR;
            end else if (m_state == 3) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_entry = 0; m_state = 0; end
            end else if (dp) begin
                if (m_state == 0) begin m_entry = dv; m_state = 1; end
                else begin m_entry = (dv + 10 > 15) ? 15 : dv + 10; m_state = 2; end
            end
            h2 = h1; h1 = h0;
            h0 = ~{minus_n, plus_n, digit_n};
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "model entry", int'(entry_value), m_entry);
            chk(cur_req, "model operand_first", int'(operand_first), m_a);
            chk(cur_req, "model operand_second", int'(operand_second), m_b);
        end
    end

    task automatic press(logic [ND-1:0] dmask, bit pl, bit mi);
        @(negedge clk);
        digit_n = ~dmask; plus_n = ~pl; minus_n = ~mi;
        repeat (3) @(negedge clk);
        digit_n = '1; plus_n = 1'b1; minus_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "entry in reset", int'(entry_value), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "entry after reset", int'(entry_value), 0);
        chk("R1", "operand_first after reset", int'(operand_first), 0);
        chk("R1", "operand_second after reset", int'(operand_second), 0);

        // R2 latency and no repeat while held
        cur_req = "R2";
        @(negedge clk);
        digit_n = ~(ND'(1) << 7);
        @(negedge clk); chk("R2", "entry after 1 edge", int'(entry_value), 0);
        @(negedge clk); chk("R2", "entry after 2 edges", int'(entry_value), 0);
        @(negedge clk); chk("R4", "entry after 3 edges", int'(entry_value), 7);
        digit_n = ~((ND'(1) << 7) | (ND'(1) << 1));
        repeat (8) @(negedge clk);
        chk("R2", "held keys give no new press", int'(entry_value), 7);
        digit_n = '1;
        repeat (4) @(negedge clk);

        cur_req = "R5";
        press(ND'(1) << 3, 0, 0);
        chk("R5", "second digit 3", int'(entry_value), 13);
        press(ND'(1) << 4, 0, 0);
        chk("R5", "third digit 4", int'(entry_value), 14);
        press(ND'(1) << 8, 0, 0);
        chk("R5", "digit 8 clamps", int'(entry_value), 15);

        cur_req = "R6";
        press('0, 1, 0);
        chk("R6", "plus first operand", int'(operand_first), 15);
        chk("R6", "plus second operand", int'(operand_second), 0);

        cur_req = "R7";
        press(ND'(1) << 2, 0, 0);
        chk("R7", "digit ignored while waiting", int'(entry_value), 15);
        repeat (CLR) @(negedge clk);
        chk("R7", "entry cleared after delay", int'(entry_value), 0);

        cur_req = "R3";
        press((ND'(1) << 1) | (ND'(1) << 4) | (ND'(1) << 6), 0, 0);
        chk("R3", "highest of 1,4,6", int'(entry_value), 6);
        press((ND'(1) << 0) | (ND'(1) << 2), 0, 0);
        chk("R3", "highest of 0,2 as second", int'(entry_value), 12);

        cur_req = "R6";
        press('0, 0, 1);
        chk("R6", "minus first operand", int'(operand_first), 12);
        chk("R6", "minus second operand", int'(operand_second), 15);

        cur_req = "R8";
        repeat (5) @(negedge clk);
        press('0, 1, 0);
        chk("R8", "retransfer first operand", int'(operand_first), 12);
        chk("R8", "retransfer second operand", int'(operand_second), 12);
        repeat (CLR - 8) @(negedge clk);
        chk("R8", "entry held past first expiry", int'(entry_value), 12);
        repeat (8) @(negedge clk);
        chk("R8", "entry cleared after restarted delay", int'(entry_value), 0);

        cur_req = "R6";
        press('0, 1, 0);
        chk("R6", "empty entry transfers zero", int'(operand_first), 0);
        chk("R6", "second after empty transfer", int'(operand_second), 12);
        repeat (CLR) @(negedge clk);
        press(ND'(1) << 5, 0, 0);
        chk("R4", "digit 5 after clear", int'(entry_value), 5);
        press(ND'(1) << 9, 1, 1);
        chk("R6", "op wins over digit, entry", int'(entry_value), 5);
        chk("R6", "plus+minus single shift first", int'(operand_first), 5);
        chk("R6", "plus+minus single shift second", int'(operand_second), 0);
        repeat (CLR) @(negedge clk);
        chk("R7", "cleared after combined press", int'(entry_value), 0);

        // mixed key activity checked against the model every cycle
        cur_req = "R5";
        for (int it = 0; it < 600; it++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                logic [ND-1:0] m;
                m = '0;
                if ($urandom_range(0, 1) == 1) m[$urandom_range(0, ND-1)] = 1'b1;
                if ($urandom_range(0, 3) == 0) m[$urandom_range(0, ND-1)] = 1'b1;
                digit_n = ~m;
                plus_n  = ($urandom_range(0, 9) != 0);
                minus_n = ($urandom_range(0, 9) != 0);
            end
        end
        digit_n = '1; plus_n = 1'b1; minus_n = 1'b1;
        repeat (CLR + 6) @(negedge clk);
        finish_run();
    end

endmodule